// File: doc/BRIEF.md
# PLL Oscillator Control Register with Programming-Rule Checker

This block holds the 32-bit control word that steers a PLL's voltage-controlled oscillator. The word contains several fields: the feedback numerator and denominator, the input source select, the enable bit and two power-down bits (one for the analog core, one for the bandgap). It also holds the regulator select bit and the per-output and all-output counter resets. Software reaches the word through a simple register bus with an address, a write strobe, write data and combinational read data. The whole word is also driven out as `ctl_word` towards the analog macro.

There are two reset inputs. A cold reset returns every field to its power-on value. A warm reset returns only some fields: the regulator select and the six per-output counter resets keep the value software last wrote. Each reset is asserted asynchronously and released in step with the clock.

Each write to the control word is checked against three programming rules. The write is always stored, even when it breaks a rule. A broken rule sets a sticky flag in a separate status word. Software clears a flag by writing 1 to its bit.

Top module: `pll_vco_ctl`

## Requirements
- R1: After a cold reset the control word reads 0x8001000D and the status word reads 0. In the control word, bit 31 is the regulator select, bits 30:25 are the per-output resets, bit 24 is the all-output reset, bits 23:22 are the source select, bits 21:16 are the denominator, bits 15:3 are the numerator, bit 2 is the analog power-down, bit 1 is the enable and bit 0 is the bandgap power-down.
- R2: A write to word address 0 stores the write data into the control word. The stored value appears on `ctl_word` and in reads of address 0 from the cycle after the write.
- R3: A warm reset by itself keeps bits 31:25 of the control word. It loads the reset values of R1 into bits 24:0 and clears the status word.
- R4: A control write whose enable bit (bit 1) equals its regulator select bit (bit 31) sets status bit 0.
- R5: A control write that changes both the numerator and the denominator relative to the stored word sets status bit 1. Changing only one of the two sets nothing.
- R6: A control write that changes the source select while `pll_bypassed` is low sets status bit 2. A change made while `pll_bypassed` is high sets no flag. Rewriting the same source value never sets a flag.
- R7: The status word is read at word address 1, with bits 31:3 reading 0. Its flags stay set until cleared. A write to address 1 clears exactly the flags whose write-data bits are 1.
- R8: A write to any address other than 0 or 1 changes neither word. A read from any such address returns 0.
- R9: A control write that breaks a rule is still stored in full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| cold_rst_n | input | 1 | Cold reset, active low, asynchronous assert |
| warm_rst_n | input | 1 | Warm reset, active low, asynchronous assert |
| pll_bypassed | input | 1 | High while the PLL output is bypassed |
| bus_addr | input | ADDR_W (4) | Word address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| ctl_word | output | 32 | Current control word to the PLL |

## Verification
The bench separates a warm reset from a cold one after software has written the retained fields. A design that cleared the regulator select or the output resets on warm reset would read back 0x8001000D instead of the kept upper bits. The bench writes both halves of the ratio together and each half alone, and changes the source with and without bypass, to catch a rule checker that compares against the write data instead of the stored word, or that ignores the bypass input. It also sends partial write-1-to-clear masks and writes to stray addresses. These catch flags cleared as a whole word, and address decoding that lets a stray write reach the control word.

// File: rtl/vco_pkg.sv
package vco_pkg;

  localparam int WORD_W = 32;
  localparam int NOUT   = 6;
  localparam int SRC_W  = 2;
  localparam int DEN_W  = 6;
  localparam int NUM_W  = 13;
  localparam int NVIO   = 3;

  typedef struct packed {
    logic             regsel;
    logic [NOUT-1:0]  out_rst;
    logic             rst_all;
    logic [SRC_W-1:0] src;
    logic [DEN_W-1:0] den;
    logic [NUM_W-1:0] num;
    logic             apwr;
    logic             en;
    logic             bgpwr;
  } vco_ctl_t;

  typedef enum int unsigned {
    VIO_REG_PAIR = 0,
    VIO_RATIO    = 1,
    VIO_SRC      = 2
  } vio_idx_e;

  localparam vco_ctl_t CTL_RST = '{
    regsel:  1'b1,
    out_rst: '0,
    rst_all: 1'b0,
    src:     '0,
    den:     DEN_W'(1),
    num:     NUM_W'(1),
    apwr:    1'b1,
    en:      1'b0,
    bgpwr:   1'b1
  };

endpackage

// File: rtl/vco_rst_sync.sv
module vco_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sh_q <= '0;
    end else begin
      sh_q <= sh_d;
    end
  end

  assign rst_n = sh_q[STAGES-1];

endmodule

// File: rtl/vco_field_regs.sv
module vco_field_regs
  import vco_pkg::*;
(
  input  logic     clk,
  input  logic     cold_rst_n,
  input  logic     sys_rst_n,
  input  logic     wr_en,
  input  vco_ctl_t wr_val,
  output vco_ctl_t ctl_q
);

  // Fields kept through warm reset
  logic            regsel_q, regsel_d;
  logic [NOUT-1:0] out_rst_q, out_rst_d;

  // Fields cleared by either reset
  logic             rst_all_q, rst_all_d;
  logic [SRC_W-1:0] src_q, src_d;
  logic [DEN_W-1:0] den_q, den_d;
  logic [NUM_W-1:0] num_q, num_d;
  logic             apwr_q, apwr_d;
  logic             en_q, en_d;
  logic             bgpwr_q, bgpwr_d;

  always_comb begin
    regsel_d  = regsel_q;
    out_rst_d = out_rst_q;
    rst_all_d = rst_all_q;
    src_d     = src_q;
    den_d     = den_q;
    num_d     = num_q;
    apwr_d    = apwr_q;
    en_d      = en_q;
    bgpwr_d   = bgpwr_q;
    if (wr_en) begin
      regsel_d  = wr_val.regsel;
      out_rst_d = wr_val.out_rst;
      rst_all_d = wr_val.rst_all;
      src_d     = wr_val.src;
      den_d     = wr_val.den;
      num_d     = wr_val.num;
      apwr_d    = wr_val.apwr;
      en_d      = wr_val.en;
      bgpwr_d   = wr_val.bgpwr;
    end
  end

  always_ff @(posedge clk or negedge cold_rst_n) begin
    if (!cold_rst_n) begin
      regsel_q  <= CTL_RST.regsel;
      out_rst_q <= CTL_RST.out_rst;
    end else if (wr_en) begin
      regsel_q  <= regsel_d;
      out_rst_q <= out_rst_d;
    end
  end

  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      rst_all_q <= CTL_RST.rst_all;
      src_q     <= CTL_RST.src;
      den_q     <= CTL_RST.den;
      num_q     <= CTL_RST.num;
      apwr_q    <= CTL_RST.apwr;
      en_q      <= CTL_RST.en;
      bgpwr_q   <= CTL_RST.bgpwr;
    end else if (wr_en) begin
      rst_all_q <= rst_all_d;
      src_q     <= src_d;
      den_q     <= den_d;
      num_q     <= num_d;
      apwr_q    <= apwr_d;
      en_q      <= en_d;
      bgpwr_q   <= bgpwr_d;
    end
  end

  always_comb begin
    ctl_q.regsel  = regsel_q;
    ctl_q.out_rst = out_rst_q;
    ctl_q.rst_all = rst_all_q;
    ctl_q.src     = src_q;
    ctl_q.den     = den_q;
    ctl_q.num     = num_q;
    ctl_q.apwr    = apwr_q;
    ctl_q.en      = en_q;
    ctl_q.bgpwr   = bgpwr_q;
  end

endmodule

// File: rtl/vco_rule_chk.sv
module vco_rule_chk
  import vco_pkg::*;
(
  input  logic            wr_en,
  input  vco_ctl_t        wr_val,
  input  vco_ctl_t        cur,
  input  logic            bypassed,
  output logic [NVIO-1:0] hit
);

  logic num_moves;
  logic den_moves;
  logic src_moves;

  always_comb begin
    num_moves = (wr_val.num != cur.num);
    den_moves = (wr_val.den != cur.den);
    src_moves = (wr_val.src != cur.src);
    hit = '0;
    if (wr_en) begin
      hit[VIO_REG_PAIR] = (wr_val.en == wr_val.regsel);
      hit[VIO_RATIO]    = num_moves && den_moves;
      hit[VIO_SRC]      = src_moves && !bypassed;
    end
  end

endmodule

// File: rtl/vco_stat_reg.sv
module vco_stat_reg #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic         clr_en,
  input  logic [N-1:0] clr_mask,
  output logic [N-1:0] flag_q
);

  for (genvar i = 0; i < N; i++) begin : g_flag
    logic bit_q;
    logic bit_d;
    logic bit_ce;

    always_comb begin
      bit_ce = set_i[i] || (clr_en && clr_mask[i]);
      bit_d  = set_i[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bit_q <= 1'b0;
      end else if (bit_ce) begin
        bit_q <= bit_d;
      end
    end

    assign flag_q[i] = bit_q;
  end

endmodule

// File: rtl/pll_vco_ctl.sv
module pll_vco_ctl
  import vco_pkg::*;
#(
  parameter int          ADDR_W    = 4,
  parameter int unsigned CTL_ADDR  = 0,
  parameter int unsigned STAT_ADDR = 1,
  parameter int          SYNC_LEN  = 2
) (
  input  logic              clk,
  input  logic              cold_rst_n,
  input  logic              warm_rst_n,
  input  logic              pll_bypassed,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  output logic [WORD_W-1:0] ctl_word
);

  localparam logic [ADDR_W-1:0] A_CTL  = ADDR_W'(CTL_ADDR);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_ADDR);

  logic            cold_sync_n;
  logic            warm_sync_n;
  logic            sys_rst_n;
  logic            sel_ctl;
  logic            sel_stat;
  logic            wr_ctl;
  logic            wr_stat;
  vco_ctl_t        wr_val;
  vco_ctl_t        ctl_q;
  logic [NVIO-1:0] vio_hit;
  logic [NVIO-1:0] stat_q;

  vco_rst_sync #(.STAGES(SYNC_LEN)) u_cold_sync (
    .clk    (clk),
    .arst_n (cold_rst_n),
    .rst_n  (cold_sync_n)
  );

  vco_rst_sync #(.STAGES(SYNC_LEN)) u_warm_sync (
    .clk    (clk),
    .arst_n (warm_rst_n),
    .rst_n  (warm_sync_n)
  );

  assign sys_rst_n = cold_sync_n & warm_sync_n;

  always_comb begin
    sel_ctl  = (bus_addr == A_CTL);
    sel_stat = (bus_addr == A_STAT);
    wr_ctl   = bus_we && sel_ctl;
    wr_stat  = bus_we && sel_stat;
    wr_val   = vco_ctl_t'(bus_wdata);
  end

  vco_field_regs u_fields (
    .clk        (clk),
    .cold_rst_n (cold_sync_n),
    .sys_rst_n  (sys_rst_n),
    .wr_en      (wr_ctl),
    .wr_val     (wr_val),
    .ctl_q      (ctl_q)
  );

  vco_rule_chk u_rules (
    .wr_en    (wr_ctl),
    .wr_val   (wr_val),
    .cur      (ctl_q),
    .bypassed (pll_bypassed),
    .hit      (vio_hit)
  );

  vco_stat_reg #(.N(NVIO)) u_stat (
    .clk      (clk),
    .rst_n    (sys_rst_n),
    .set_i    (vio_hit),
    .clr_en   (wr_stat),
    .clr_mask (bus_wdata[NVIO-1:0]),
    .flag_q   (stat_q)
  );

  assign ctl_word = ctl_q;

  always_comb begin
    bus_rdata = '0;
    if (sel_ctl) begin
      bus_rdata = ctl_q;
    end else if (sel_stat) begin
      bus_rdata = {{(WORD_W-NVIO){1'b0}}, stat_q};
    end
  end

endmodule

// File: rtl/vco_ctl_chk.sv
module vco_ctl_chk #(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pll_bypassed,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       ctl_word,
  input logic [2:0]        stat_q
);

  logic       hit_ctl;
  logic       hit_stat;
  logic       hit_other;
  logic [2:0] keep_mask;

  assign hit_ctl   = bus_we && (bus_addr == ADDR_W'(0));
  assign hit_stat  = bus_we && (bus_addr == ADDR_W'(1));
  assign hit_other = bus_we && !hit_ctl && !hit_stat;
  assign keep_mask = hit_stat ? ~bus_wdata[2:0] : 3'b111;

  // R2, R9
  a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    hit_ctl |=> ctl_word == $past(bus_wdata));

  a_r4_reg_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_ctl && (bus_wdata[1] == bus_wdata[31])) |=> stat_q[0]);

  a_r5_ratio_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_ctl && (bus_wdata[15:3] != ctl_word[15:3]) && (bus_wdata[21:16] != ctl_word[21:16]))
      |=> stat_q[1]);

  a_r6_src_live: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_ctl && !pll_bypassed && (bus_wdata[23:22] != ctl_word[23:22])) |=> stat_q[2]);

  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(stat_q & keep_mask) & ~stat_q) == 3'b000));

  a_r8_stray_write: assert property (@(posedge clk) disable iff (!rst_n)
    hit_other |=> ($stable(ctl_word) && $stable(stat_q)));

endmodule

bind pll_vco_ctl vco_ctl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (sys_rst_n),
  .pll_bypassed (pll_bypassed),
  .bus_addr     (bus_addr),
  .bus_we       (bus_we),
  .bus_wdata    (bus_wdata),
  .ctl_word     (ctl_word),
  .stat_q       (stat_q)
);

// File: tb/sim_pll_vco_ctl.sv
`timescale 1ns/1ps
module sim_pll_vco_ctl;

  localparam int unsigned RST_WORD  = 32'h8001000D;
  localparam int unsigned KEEP_MASK = 32'hFE000000;

  logic        clk = 1'b0;
  logic        cold_rst_n = 1'b0;
  logic        warm_rst_n = 1'b0;
  logic        pll_bypassed = 1'b0;
  logic [3:0]  bus_addr = 4'd0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;
  logic [31:0] ctl_word;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pll_vco_ctl u0 (
    .clk          (clk),
    .cold_rst_n   (cold_rst_n),
    .warm_rst_n   (warm_rst_n),
    .pll_bypassed (pll_bypassed),
    .bus_addr     (bus_addr),
    .bus_we       (bus_we),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .ctl_word     (ctl_word)
  );

  // Behavioural reference model
  logic [31:0] m_ctl = RST_WORD;
  logic [2:0]  m_stat = 3'd0;
  int          cold_cnt = 0;
  int          warm_cnt = 0;
  bit          model_live = 0;

  always @(posedge clk) begin
    bit          cold_act;
    bit          warm_act;
    logic [2:0]  flags;
    cold_act = !cold_rst_n || (cold_cnt < 2);
    warm_act = !warm_rst_n || (warm_cnt < 2);
    cold_cnt = cold_rst_n ? ((cold_cnt < 2) ? cold_cnt + 1 : 2) : 0;
    warm_cnt = warm_rst_n ? ((warm_cnt < 2) ? warm_cnt + 1 : 2) : 0;
    if (cold_act) begin
      m_ctl  = RST_WORD;
      m_stat = 3'd0;
    end else if (warm_act) begin
      m_ctl  = (m_ctl & KEEP_MASK) | (RST_WORD & ~KEEP_MASK);
      m_stat = 3'd0;
    end else if (bus_we && bus_addr == 4'd0) begin
      flags    = 3'd0;
      flags[0] = (bus_wdata[1] == bus_wdata[31]);
      flags[1] = (bus_wdata[15:3] != m_ctl[15:3]) && (bus_wdata[21:16] != m_ctl[21:16]);
      flags[2] = (bus_wdata[23:22] != m_ctl[23:22]) && !pll_bypassed;
      m_stat   = m_stat | flags;
      m_ctl    = bus_wdata;
    end else if (bus_we && bus_addr == 4'd1) begin
      m_stat = m_stat & ~bus_wdata[2:0];
    end
    model_live = 1;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    logic [31:0] exp_rd;
    if (model_live && !done) begin
      check("R2 ctl_word vs model", ctl_word, m_ctl);
      exp_rd = (bus_addr == 4'd0) ? m_ctl :
               (bus_addr == 4'd1) ? {29'd0, m_stat} : 32'd0;
      check("R8 bus_rdata vs model", bus_rdata, exp_rd);
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); #1;
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk); #1;
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); #1;
    bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    idle(4);
    #1 cold_rst_n = 1'b1; warm_rst_n = 1'b1;
    idle(4);

    // R1 reset state
    rd(4'd0, r); check("R1 ctl after cold reset", r, RST_WORD);
    rd(4'd1, r); check("R1 status after cold reset", r, 32'd0);

    // R2 legal write, numerator only
    wr(4'd0, 32'h0001002A);
    rd(4'd0, r); check("R2 ctl readback", r, 32'h0001002A);
    check("R2 ctl_word port", ctl_word, 32'h0001002A);
    rd(4'd1, r); check("R5 single ratio change no flag", r, 32'd0);

    // R4 enable equals regulator select; R9 still stored
    wr(4'd0, 32'h00010028);
    rd(4'd1, r); check("R4 reg pair flag", r, 32'h1);
    rd(4'd0, r); check("R9 violating write stored", r, 32'h00010028);

    // R7 partial clear then full clear
    wr(4'd1, 32'h00000002);
    rd(4'd1, r); check("R7 unrelated clear keeps flag", r, 32'h1);
    wr(4'd1, 32'hFFFFFFF9);
    rd(4'd1, r); check("R7 w1c clears flag", r, 32'd0);

    // R5 both ratio parts change
    wr(4'd0, 32'h0002003A);
    rd(4'd1, r); check("R5 ratio pair flag", r, 32'h2);
    wr(4'd1, 32'h7);

    // R6 source select change
    pll_bypassed = 1'b0;
    wr(4'd0, 32'h0042003A);
    rd(4'd1, r); check("R6 src change live flag", r, 32'h4);
    wr(4'd1, 32'h7);
    wr(4'd0, 32'h0042003A);
    rd(4'd1, r); check("R6 same src no flag", r, 32'd0);
    pll_bypassed = 1'b1;
    wr(4'd0, 32'h0082003A);
    rd(4'd1, r); check("R6 src change bypassed no flag", r, 32'd0);

    // R8 stray address
    wr(4'd2, 32'hFFFFFFFF);
    wr(4'd15, 32'hFFFFFFFF);
    rd(4'd0, r); check("R8 stray write ctl unchanged", r, 32'h0082003A);
    rd(4'd1, r); check("R8 stray write status unchanged", r, 32'd0);
    rd(4'd2, r); check("R8 stray read zero", r, 32'd0);
    rd(4'd15, r); check("R8 stray read top zero", r, 32'd0);

    // R3 warm reset keeps upper fields
    wr(4'd0, 32'h00820038);
    wr(4'd0, 32'hD4820038);
    rd(4'd1, r); check("R4 flag before warm reset", r, 32'h1);
    @(negedge clk); #1 warm_rst_n = 1'b0;
    idle(2);
    #1 warm_rst_n = 1'b1;
    idle(4);
    rd(4'd0, r); check("R3 warm reset keeps retained bits", r, 32'hD401000D);
    rd(4'd1, r); check("R3 warm reset clears status", r, 32'd0);

    // R1 cold reset restores everything
    @(negedge clk); #1 cold_rst_n = 1'b0;
    idle(2);
    #1 cold_rst_n = 1'b1;
    idle(4);
    rd(4'd0, r); check("R1 cold reset full restore", r, RST_WORD);

    idle(2);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule